// File: doc/BRIEF.md
# Global Performance Status Tracker

This block generates the active-low "all requests globally performed" status that a system agent presents to one processor. When the status is asserted (driven low), every request the processor has issued has been globally performed, and the processor may retire its memory-barrier instruction. When the status is negated (driven high), at least one request is still outstanding, and the barrier has to wait.

The tracker watches three event streams. The first carries completion responses for reads and upgrades. The second carries address cycles of non-block writes. Each of these two streams has a tag that says whether the request is still pending global performance. The third stream carries later notices that one pending request has now been globally performed. A saturating counter holds the number of pending requests.

The two request kinds have different negation deadlines. A pending completion response negates the status combinationally, in the same cycle as the response. A pending write passes through one register stage, so the status is negated in the cycle after the address cycle. A mode input holds the status asserted for systems that use sequential consistency.

Top module: `gperf_status_tracker`

## Requirements
- R1: A synchronous reset clears the outstanding count and holds `gperf_n_o` low and `underflow_o` low.
- R2: When sequential mode is off, `gperf_n_o` stays high in every cycle in which the registered outstanding count is nonzero.
- R3: A read/upgrade completion (`cmpl_valid_i`=1) with `cmpl_pending_i`=1 drives `gperf_n_o` high in the same cycle, and the status stays high until a matching notice arrives.
- R4: A write address cycle (`wr_valid_i`=1) with `wr_pending_i`=1 drives `gperf_n_o` high from the next cycle, which is within two cycles of the address cycle.
- R5: Completions and write address cycles whose pending tag is 0 do not change the count or the status.
- R6: Each performed notice (`done_i`=1) lowers the count by one. The status returns low in the cycle after the notice that brings the count to zero.
- R7: An increment and a notice in the same cycle leave the count unchanged. A pending completion and a staged pending write in the same cycle add two.
- R8: A notice that arrives when the count is zero and there is no increment raises `underflow_o` for exactly one cycle, and the count stays at zero.
- R9: When `seq_mode_i`=1, `gperf_n_o` is held low. The count keeps tracking, so the status reflects any outstanding requests as soon as the mode is cleared.
- R10: The count saturates at 2^CNT_W-1 (31 by default). Increments beyond that value are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seq_mode_i | input | 1 | Sequential-consistency mode: holds the status asserted |
| cmpl_valid_i | input | 1 | Completion response for a read or upgrade |
| cmpl_pending_i | input | 1 | The completed request is not yet globally performed |
| wr_valid_i | input | 1 | Address cycle of a non-block write |
| wr_pending_i | input | 1 | The write is not yet globally performed |
| done_i | input | 1 | One pending request has become globally performed |
| gperf_n_o | output | 1 | Active-low status: low means all requests are performed |
| underflow_o | output | 1 | One-cycle flag for a notice that arrived with nothing pending |

## Verification
The corner that is hardest to reach is the cycle in which the counter sees two increments and a decrement together, and the cycle in which it sits at its ceiling. The double increment needs a pending write address cycle, followed one cycle later by a pending completion, so that the staged write and the completion meet. The ceiling needs 32 back-to-back pending completions. The bench then counts notices, checking that the status is still high after 30 notices and falls after the 31st, which exposes both a wrapping counter and a lost increment.

// File: rtl/gperf_pkg.sv
package gperf_pkg;
    localparam int GP_CNT_W = 5;

    typedef logic [1:0] inc_t;

    typedef struct packed {
        logic wr_staged;
    } stage_t;
endpackage

// File: rtl/gperf_event_stage.sv
module gperf_event_stage
    import gperf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmpl_valid_i,
    input  logic cmpl_pending_i,
    input  logic wr_valid_i,
    input  logic wr_pending_i,
    output logic rd_now_o,
    output logic wr_staged_o,
    output inc_t inc_o
);
    stage_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.wr_staged = wr_valid_i && wr_pending_i;
        rd_now_o       = cmpl_valid_i && cmpl_pending_i;
        inc_o          = {1'b0, rd_now_o} + {1'b0, st_q.wr_staged};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_staged_o = st_q.wr_staged;

    // R4: a pending write is staged in the following cycle
    a_r4_write_staged: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && wr_pending_i) |=> wr_staged_o);

    // R5: a performed-tagged write never reaches the stage
    a_r5_tag_filter: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && !wr_pending_i) |=> !wr_staged_o);
endmodule

// File: rtl/gperf_pending_counter.sv
module gperf_pending_counter
    import gperf_pkg::*;
#(
    parameter int CNT_W = GP_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  inc_t             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] count_o,
    output logic             underflow_o
);
    localparam logic [CNT_W:0]   SUM_MAX = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             underflow;
    } cnt_t;

    cnt_t           cs_d, cs_q;
    logic [CNT_W:0] sum;

    always_comb begin
        cs_d = cs_q;
        sum  = {1'b0, cs_q.count} + {{(CNT_W-1){1'b0}}, inc_i};
        cs_d.underflow = dec_i && (sum == '0);
        if (dec_i && (sum != '0)) sum = sum - 1'b1;
        if (sum > SUM_MAX) sum = SUM_MAX;
        cs_d.count = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) cs_q <= '0;
        else     cs_q <= cs_d;
    end

    assign count_o     = cs_q.count;
    assign underflow_o = cs_q.underflow;

    // R8: notice with nothing pending flags and holds zero
    a_r8_underflow: assert property (@(posedge clk) disable iff (rst)
        (dec_i && count_o == '0 && inc_i == 2'd0) |=> (underflow_o && count_o == '0));

    // R7: one increment with one notice leaves the count unchanged
    a_r7_balanced: assert property (@(posedge clk) disable iff (rst)
        (dec_i && inc_i == 2'd1) |=> (count_o == $past(count_o)));

    // R6: a lone notice lowers a nonzero count by one
    a_r6_decrement: assert property (@(posedge clk) disable iff (rst)
        (dec_i && inc_i == 2'd0 && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

    // R10: the ceiling holds without a notice
    a_r10_ceiling: assert property (@(posedge clk) disable iff (rst)
        (count_o == CNT_MAX && !dec_i) |=> (count_o == CNT_MAX));
endmodule

// File: rtl/gperf_status_tracker.sv
module gperf_status_tracker
    import gperf_pkg::*;
#(
    parameter int CNT_W = GP_CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic seq_mode_i,
    input  logic cmpl_valid_i,
    input  logic cmpl_pending_i,
    input  logic wr_valid_i,
    input  logic wr_pending_i,
    input  logic done_i,
    output logic gperf_n_o,
    output logic underflow_o
);
    logic             rd_now;
    logic             wr_staged;
    inc_t             inc;
    logic [CNT_W-1:0] count;

    gperf_event_stage u_stage (
        .clk            (clk),
        .rst            (rst),
        .cmpl_valid_i   (cmpl_valid_i),
        .cmpl_pending_i (cmpl_pending_i),
        .wr_valid_i     (wr_valid_i),
        .wr_pending_i   (wr_pending_i),
        .rd_now_o       (rd_now),
        .wr_staged_o    (wr_staged),
        .inc_o          (inc)
    );

    gperf_pending_counter #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst         (rst),
        .inc_i       (inc),
        .dec_i       (done_i),
        .count_o     (count),
        .underflow_o (underflow_o)
    );

    always_comb begin
        gperf_n_o = !seq_mode_i && (rd_now || wr_staged || (count != '0));
    end

    // R3: pending completion negates status in the same cycle
    a_r3_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (!seq_mode_i && cmpl_valid_i && cmpl_pending_i) |-> gperf_n_o);

    // R4: pending write negates status by the next cycle
    a_r4_write_deadline: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && wr_pending_i) |=> (seq_mode_i || gperf_n_o));

    // R2: outstanding count keeps status negated
    a_r2_busy: assert property (@(posedge clk) disable iff (rst)
        (!seq_mode_i && count != '0) |-> gperf_n_o);

    // R9: sequential mode holds status asserted
    a_r9_seq_hold: assert property (@(posedge clk) disable iff (rst)
        seq_mode_i |-> !gperf_n_o);
endmodule

// File: tb/tb_gperf_status_tracker.sv
`timescale 1ns/1ps
module tb_gperf_status_tracker;
    logic clk = 1'b0;
    logic rst, seq_mode, cv, cp, wv, wp, dn;
    logic gperf_n, uflow;
    int   checks = 0;
    int   failures = 0;

    always #2.5 clk = ~clk;

    gperf_status_tracker dut (
        .clk            (clk),
        .rst            (rst),
        .seq_mode_i     (seq_mode),
        .cmpl_valid_i   (cv),
        .cmpl_pending_i (cp),
        .wr_valid_i     (wv),
        .wr_pending_i   (wp),
        .done_i         (dn),
        .gperf_n_o      (gperf_n),
        .underflow_o    (uflow)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic c_v, input logic c_p, input logic w_v,
                         input logic w_p, input logic d);
        @(negedge clk);
        cv = c_v; cp = c_p; wv = w_v; wp = w_p; dn = d;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic notice();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic test_reset();
        rst = 1'b1; seq_mode = 1'b0;
        repeat (3) idle();
        check("R1 status", gperf_n, 1'b0);
        check("R1 underflow", uflow, 1'b0);
        @(negedge clk); rst = 1'b0;
        idle();
        check("R1 after release", gperf_n, 1'b0);
    endtask

    task automatic test_read();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3 same cycle", gperf_n, 1'b1);
        idle();
        check("R2 held", gperf_n, 1'b1);
        idle();
        check("R2 held later", gperf_n, 1'b1);
        notice();
        check("R6 before update", gperf_n, 1'b1);
        idle();
        check("R6 cleared", gperf_n, 1'b0);
    endtask

    task automatic test_write();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        idle();
        check("R4 next cycle", gperf_n, 1'b1);
        idle();
        check("R4 held", gperf_n, 1'b1);
        notice();
        idle();
        check("R4 cleared", gperf_n, 1'b0);
    endtask

    task automatic test_tags();
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 same cycle", gperf_n, 1'b0);
        idle();
        check("R5 next", gperf_n, 1'b0);
        idle();
        check("R5 later", gperf_n, 1'b0);
        notice();
        idle();
        check("R5 count still zero", uflow, 1'b1);
        idle();
    endtask

    task automatic test_overlap();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R7 balanced cycle", gperf_n, 1'b1);
        idle();
        check("R7 still one", gperf_n, 1'b1);
        notice();
        idle();
        check("R7 balanced cleared", gperf_n, 1'b0);
        check("R7 no underflow", uflow, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        idle();
        notice();
        idle();
        check("R7 double add left one", gperf_n, 1'b1);
        notice();
        idle();
        check("R7 double add cleared", gperf_n, 1'b0);
        check("R7 double add no underflow", uflow, 1'b0);
    endtask

    task automatic test_underflow();
        notice();
        idle();
        check("R8 flag", uflow, 1'b1);
        check("R8 status", gperf_n, 1'b0);
        idle();
        check("R8 one cycle", uflow, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        notice();
        idle();
        check("R8 count held at zero", gperf_n, 1'b0);
    endtask

    task automatic test_seq();
        @(negedge clk); seq_mode = 1'b1;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 held low", gperf_n, 1'b0);
        idle();
        check("R9 held low later", gperf_n, 1'b0);
        @(negedge clk); seq_mode = 1'b0;
        idle();
        check("R9 tracked count", gperf_n, 1'b1);
        notice();
        idle();
        check("R9 cleared", gperf_n, 1'b0);
    endtask

    task automatic test_saturate();
        for (int i = 0; i < 32; i++) drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        idle();
        check("R10 no wrap", gperf_n, 1'b1);
        for (int i = 0; i < 30; i++) notice();
        idle();
        check("R10 one left", gperf_n, 1'b1);
        notice();
        idle();
        check("R10 drained", gperf_n, 1'b0);
        check("R10 no underflow", uflow, 1'b0);
    endtask

    initial begin
        cv = 1'b0; cp = 1'b0; wv = 1'b0; wp = 1'b0; dn = 1'b0;
        test_reset();
        test_read();
        test_write();
        test_tags();
        test_overlap();
        test_underflow();
        test_seq();
        test_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule